// File: doc/BRIEF.md
# TDM Slot Routing Map

This block decides, slot by slot, which internal serial channel owns each time slot of a TDM frame. It keeps two independent routing programs, one for the transmit direction and one for the receive direction. Each program is a short list of runs. A run gives a number of consecutive slots and the channel code that owns them. The port timing logic supplies a slot-start strobe and the index of the slot that is starting. Index 0 marks the start of a new frame.

On transmit, the selected channel code picks which channel's serial bit goes onto the line. Unused slots hold the line at an idle level. On receive, the selected code raises the write strobe of exactly one channel, or of none when the slot is unused. Software edits a shadow copy of each program through a small write port. A program only takes effect at the next frame start, so a frame never runs under a half-edited table.

Top module: `slot_route_map`

## Requirements
- R1: After reset, both directions select code 0. `tx_act`, `rx_act`, `ch_rx_we` and `wr_err` are low, and `line_tx` sits at the idle level 1.
- R2: Runs are consumed in list order starting at slot 0. Run k covers as many consecutive slots as its count. `tx_sel`/`rx_sel` take the new slot's code on the clock edge that samples `slot_start`, and hold it until the next `slot_start`.
- R3: On transmit, a code k in 1..5 drives `line_tx` from `ch_tx_bit[k-1]`. Code 0 drives `line_tx` to 1 and leaves `tx_act` low.
- R4: On receive, a code k in 1..5 raises only `ch_rx_we[k-1]` (and `rx_act`). Code 0 leaves every strobe low.
- R5: `wr_dir`=0 writes the transmit program and `wr_dir`=1 writes the receive program. A write to one direction never alters the other.
- R6: Slots past the end of the last run are unused (code 0) until the next frame start.
- R7: An accepted write goes to the shadow program only. It becomes active at the next `slot_start` with `slot_idx`=0, and the frame in progress keeps the old program.
- R8: A write with a count of 0, a count above 64, or a code above 5 is discarded. `wr_err` is 1 in the cycle after such a write and 0 after an accepted one.
- R9: Every `slot_start` with `slot_idx`=0 restarts the walk at run 0, even when the previous frame has not used up its runs.
- R10: A run of count 64 covers exactly 64 slots, and a program of 64 runs walks all 64 entries in order.
- R11: An accepted write with `wr_last`=1 at entry i sets the program length to i+1 runs. Writes with `wr_last`=0 leave the length unchanged. The length after reset is 1 run of count 1, code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | One-cycle strobe at the start of a slot |
| slot_idx | input | 12 | Index of the starting slot; 0 means frame start |
| wr_en | input | 1 | Table write request |
| wr_dir | input | 1 | 0 = transmit program, 1 = receive program |
| wr_idx | input | 6 | Run entry position |
| wr_count | input | 7 | Slot count of the run (1..64) |
| wr_code | input | 3 | Channel code (0 unused, 1..5 channel) |
| wr_last | input | 1 | Entry is the last run of the program |
| wr_err | output | 1 | Previous cycle's write was rejected |
| ch_tx_bit | input | 5 | Serial transmit bit of each channel |
| line_tx | output | 1 | Transmit line |
| tx_sel | output | 3 | Transmit channel code of current slot |
| tx_act | output | 1 | Current transmit slot is assigned |
| rx_sel | output | 3 | Receive channel code of current slot |
| rx_act | output | 1 | Current receive slot is assigned |
| ch_rx_we | output | 5 | Per-channel receive write strobe |

## Verification
The bound checker watches several properties on every cycle. The receive strobes are at most one-hot. An unassigned transmit slot holds the line idle. Neither selection moves without a slot strobe. No illegal code ever reaches a selection, and an out-of-range code always raises the error flag. Only the bench's scenarios can show the slot-by-slot mapping of a program, the deferral of edits to the next frame boundary, restarts on short frames, tails past the last run, and the 64-run and 64-slot limits. It compares each of these against its own run-list model.

// File: rtl/slot_route_pkg.sv
package slot_route_pkg;
    localparam int CODE_W  = 3;
    localparam int NUM_CH  = 5;
    localparam int MAX_RUN = 64;
    localparam int RUN_W   = $clog2(MAX_RUN + 1);

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } route_dir_e;

    typedef struct packed {
        logic [RUN_W-1:0]  run;
        logic [CODE_W-1:0] chan;
    } route_ent_t;

    localparam route_ent_t EMPTY_ENT = '{run: RUN_W'(1), chan: CODE_W'(0)};

    function automatic logic ent_ok(route_ent_t e);
        return (e.run != '0) && (e.run <= RUN_W'(MAX_RUN)) && (e.chan <= CODE_W'(NUM_CH));
    endfunction
endpackage

// File: rtl/route_table.sv
module route_table
    import slot_route_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  route_ent_t       wr_ent,
    input  logic             wr_last,
    input  logic             swap,
    input  logic [IDX_W-1:0] rd_idx,
    output route_ent_t       rd_ent,
    output logic [LEN_W-1:0] rd_len,
    output route_ent_t       head_ent,
    output logic [LEN_W-1:0] head_len
);
    route_ent_t       shadow [DEPTH];
    route_ent_t       active [DEPTH];
    logic [LEN_W-1:0] sh_len;
    logic [LEN_W-1:0] act_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow[i] <= EMPTY_ENT;
                active[i] <= EMPTY_ENT;
            end
            sh_len  <= LEN_W'(1);
            act_len <= LEN_W'(1);
        end else begin
            if (wr_en) begin
                shadow[wr_idx] <= wr_ent;
                if (wr_last) sh_len <= LEN_W'(wr_idx) + LEN_W'(1);
            end
            if (swap) begin
                active  <= shadow;
                act_len <= sh_len;
            end
        end
    end

    assign rd_ent   = active[rd_idx];
    assign rd_len   = act_len;
    assign head_ent = shadow[0];
    assign head_len = sh_len;
endmodule

// File: rtl/route_walker.sv
module route_walker
    import slot_route_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    input  logic              frame_start,
    input  route_ent_t        head_ent,
    output logic [IDX_W-1:0]  rd_idx,
    input  route_ent_t        rd_ent,
    input  logic [LEN_W-1:0]  rd_len,
    output logic [CODE_W-1:0] chan
);
    logic [IDX_W-1:0] idx;
    logic [RUN_W-1:0] left;
    logic             done;
    logic             at_end;

    assign rd_idx = idx + IDX_W'(1);
    assign at_end = (LEN_W'(idx) + LEN_W'(1)) >= rd_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            left <= '0;
            done <= 1'b1;
            chan <= '0;
        end else if (slot_start) begin
            if (frame_start) begin
                idx  <= '0;
                left <= head_ent.run - RUN_W'(1);
                chan <= head_ent.chan;
                done <= 1'b0;
            end else if (done) begin
                chan <= '0;
            end else if (left != '0) begin
                left <= left - RUN_W'(1);
            end else if (!at_end) begin
                idx  <= rd_idx;
                left <= rd_ent.run - RUN_W'(1);
                chan <= rd_ent.chan;
            end else begin
                done <= 1'b1;
                chan <= '0;
            end
        end
    end
endmodule

// File: rtl/route_steer.sv
module route_steer
    import slot_route_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic [CODE_W-1:0] tx_chan,
    input  logic [CODE_W-1:0] rx_chan,
    input  logic [NUM_CH-1:0] ch_tx_bit,
    output logic              line_tx,
    output logic [NUM_CH-1:0] ch_rx_we
);
    always_comb begin
        line_tx = IDLE_LVL;
        for (int i = 0; i < NUM_CH; i++) begin
            if (tx_chan == CODE_W'(i + 1)) line_tx = ch_tx_bit[i];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_strobe
        assign ch_rx_we[g] = (rx_chan == CODE_W'(g + 1));
    end
endmodule

// File: rtl/slot_route_map.sv
module slot_route_map
    import slot_route_pkg::*;
#(
    parameter int   DEPTH    = 64,
    parameter int   SLOT_W   = 12,
    parameter logic IDLE_LVL = 1'b1,
    localparam int  IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int  LEN_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              wr_en,
    input  logic              wr_dir,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [RUN_W-1:0]  wr_count,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_last,
    output logic              wr_err,
    input  logic [NUM_CH-1:0] ch_tx_bit,
    output logic              line_tx,
    output logic [CODE_W-1:0] tx_sel,
    output logic              tx_act,
    output logic [CODE_W-1:0] rx_sel,
    output logic              rx_act,
    output logic [NUM_CH-1:0] ch_rx_we
);
    route_ent_t        new_ent;
    logic              new_ok;
    logic              frame_start;
    logic [CODE_W-1:0] chan [2];

    assign new_ent     = '{run: wr_count, chan: wr_code};
    assign new_ok      = ent_ok(new_ent);
    assign frame_start = slot_start && (slot_idx == '0);

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= wr_en && !new_ok;
    end

    for (genvar d = 0; d < 2; d++) begin : g_dir
        route_ent_t       rd_ent;
        route_ent_t       head_ent;
        logic [IDX_W-1:0] rd_idx;
        logic [LEN_W-1:0] rd_len;
        logic [LEN_W-1:0] head_len;
        logic             dir_wr;

        assign dir_wr = wr_en && new_ok && (route_dir_e'(wr_dir) == route_dir_e'(d));

        route_table #(.DEPTH(DEPTH)) u_table (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (dir_wr),
            .wr_idx   (wr_idx),
            .wr_ent   (new_ent),
            .wr_last  (wr_last),
            .swap     (frame_start),
            .rd_idx   (rd_idx),
            .rd_ent   (rd_ent),
            .rd_len   (rd_len),
            .head_ent (head_ent),
            .head_len (head_len)
        );

        route_walker #(.DEPTH(DEPTH)) u_walk (
            .clk         (clk),
            .rst         (rst),
            .slot_start  (slot_start),
            .frame_start (frame_start),
            .head_ent    (head_ent),
            .rd_idx      (rd_idx),
            .rd_ent      (rd_ent),
            .rd_len      (rd_len),
            .chan        (chan[d])
        );
    end

    assign tx_sel = chan[0];
    assign rx_sel = chan[1];
    assign tx_act = (chan[0] != '0);
    assign rx_act = (chan[1] != '0);

    route_steer #(.IDLE_LVL(IDLE_LVL)) u_steer (
        .tx_chan   (chan[0]),
        .rx_chan   (chan[1]),
        .ch_tx_bit (ch_tx_bit),
        .line_tx   (line_tx),
        .ch_rx_we  (ch_rx_we)
    );
endmodule

// File: rtl/slot_route_map_chk.sv
module slot_route_map_chk
    import slot_route_pkg::*;
#(
    parameter logic IDLE_LVL = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_start,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_code,
    input logic              wr_err,
    input logic              line_tx,
    input logic [CODE_W-1:0] tx_sel,
    input logic              tx_act,
    input logic [CODE_W-1:0] rx_sel,
    input logic [NUM_CH-1:0] ch_rx_we
);
    AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ch_rx_we)); // R4
    AST_TX_IDLE: assert property (@(posedge clk) disable iff (rst) !tx_act |-> line_tx == IDLE_LVL); // R3
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst) !slot_start |=> $stable(tx_sel) && $stable(rx_sel)); // R2
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst) (tx_sel <= CODE_W'(NUM_CH)) && (rx_sel <= CODE_W'(NUM_CH))); // R8
    AST_BAD_CODE_ERR: assert property (@(posedge clk) disable iff (rst) (wr_en && wr_code > CODE_W'(NUM_CH)) |=> wr_err); // R8
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst) !wr_en |=> !wr_err); // R8
endmodule

bind slot_route_map slot_route_map_chk #(.IDLE_LVL(IDLE_LVL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .wr_en      (wr_en),
    .wr_code    (wr_code),
    .wr_err     (wr_err),
    .line_tx    (line_tx),
    .tx_sel     (tx_sel),
    .tx_act     (tx_act),
    .rx_sel     (rx_sel),
    .ch_rx_we   (ch_rx_we)
);

// File: tb/slot_route_map_test.sv
`timescale 1ns/1ps
module slot_route_map_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_start = 1'b0;
    logic [11:0] slot_idx = '0;
    logic        wr_en = 1'b0;
    logic        wr_dir = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [6:0]  wr_count = '0;
    logic [2:0]  wr_code = '0;
    logic        wr_last = 1'b0;
    logic        wr_err;
    logic [4:0]  ch_tx_bit = '0;
    logic        line_tx;
    logic [2:0]  tx_sel;
    logic        tx_act;
    logic [2:0]  rx_sel;
    logic        rx_act;
    logic [4:0]  ch_rx_we;

    always #4 clk = ~clk;

    slot_route_map uut (
        .clk(clk), .rst(rst), .slot_start(slot_start), .slot_idx(slot_idx),
        .wr_en(wr_en), .wr_dir(wr_dir), .wr_idx(wr_idx), .wr_count(wr_count),
        .wr_code(wr_code), .wr_last(wr_last), .wr_err(wr_err),
        .ch_tx_bit(ch_tx_bit), .line_tx(line_tx), .tx_sel(tx_sel), .tx_act(tx_act),
        .rx_sel(rx_sel), .rx_act(rx_act), .ch_rx_we(ch_rx_we)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  ended = 0;

    // run-list model: shadow and active copies per direction
    int sh_cnt [2][64];
    int sh_code[2][64];
    int sh_len [2];
    int ac_cnt [2][64];
    int ac_code[2][64];
    int ac_len [2];

    // {dir, idx[5:0], count[6:0], code[2:0], last, expect_err}
    localparam int NVEC = 10;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 6'd0, 7'd2,  3'd0, 1'b0, 1'b0},
        {1'b0, 6'd1, 7'd24, 3'd3, 1'b0, 1'b0},
        {1'b0, 6'd2, 7'd1,  3'd0, 1'b0, 1'b0},
        {1'b0, 6'd3, 7'd5,  3'd2, 1'b1, 1'b0},
        {1'b1, 6'd0, 7'd3,  3'd1, 1'b0, 1'b0},
        {1'b1, 6'd1, 7'd4,  3'd4, 1'b0, 1'b0},
        {1'b1, 6'd2, 7'd2,  3'd5, 1'b1, 1'b0},
        {1'b0, 6'd1, 7'd0,  3'd1, 1'b0, 1'b1},
        {1'b1, 6'd0, 7'd3,  3'd6, 1'b0, 1'b1},
        {1'b1, 6'd1, 7'd65, 3'd2, 1'b1, 1'b1}
    };

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mexp(int d, int s);
        int acc = 0;
        for (int e = 0; e < ac_len[d]; e++) begin
            if (s < acc + ac_cnt[d][e]) return ac_code[d][e];
            acc += ac_cnt[d][e];
        end
        return 0;
    endfunction

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            for (int e = 0; e < 64; e++) begin
                sh_cnt[d][e] = 1; sh_code[d][e] = 0;
                ac_cnt[d][e] = 1; ac_code[d][e] = 0;
            end
            sh_len[d] = 1; ac_len[d] = 1;
        end
    endtask

    task automatic wr(bit d, int idx, int cnt, int code, bit last, bit experr, string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_dir = d; wr_idx = 6'(idx); wr_count = 7'(cnt);
        wr_code = 3'(code); wr_last = last;
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " wr_err"}, int'(wr_err), int'(experr));
        if (!experr) begin
            sh_cnt[d][idx] = cnt; sh_code[d][idx] = code;
            if (last) sh_len[d] = idx + 1;
        end
    endtask

    task automatic step(int s, string tag);
        int et, er;
        logic [4:0] pat;
        pat = 5'(s * 13 + 7);
        @(negedge clk);
        slot_start = 1'b1; slot_idx = 12'(s); ch_tx_bit = pat;
        if (s == 0) begin
            ac_cnt = sh_cnt; ac_code = sh_code; ac_len = sh_len;
        end
        @(negedge clk);
        slot_start = 1'b0;
        et = mexp(0, s);
        er = mexp(1, s);
        chk({tag, " tx_sel"}, int'(tx_sel), et);
        chk("R3 line_tx", int'(line_tx), (et != 0) ? int'(pat[et-1]) : 1);
        chk("R3 tx_act", int'(tx_act), int'(et != 0));
        chk({tag, " R5 rx_sel"}, int'(rx_sel), er);
        chk("R4 ch_rx_we", int'(ch_rx_we), (er != 0) ? (1 << (er - 1)) : 0);
        chk("R4 rx_act", int'(rx_act), int'(er != 0));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 tx_act", int'(tx_act), 0);
        chk("R1 rx_act", int'(rx_act), 0);
        chk("R1 line_tx", int'(line_tx), 1);
        chk("R1 ch_rx_we", int'(ch_rx_we), 0);
        chk("R1 wr_err", int'(wr_err), 0);
        step(3, "R1");

        // vector program: legal runs plus R8 rejections, R5 directions, R11 lengths
        for (int v = 0; v < NVEC; v++)
            wr(VEC[v][18], int'(VEC[v][17:12]), int'(VEC[v][11:5]), int'(VEC[v][4:2]),
               VEC[v][1], VEC[v][0], VEC[v][0] ? "R8" : "R11");

        // R7: nothing active until the next frame start
        step(5, "R7");
        // full frame: R2 walk, R6 rx tail past run list, R8 rejects not stored
        for (int s = 0; s < 32; s++) step(s, (s >= 9) ? "R6" : "R2");
        for (int s = 32; s < 36; s++) step(s, "R6");

        // R7: mid-frame edit keeps the running frame on the old program
        for (int s = 0; s < 6; s++) step(s, "R7");
        wr(1'b0, 1, 24, 1, 1'b0, 1'b0, "R7");
        for (int s = 6; s < 32; s++) step(s, "R7");
        for (int s = 0; s < 32; s++) step(s, "R7");

        // R9: short frame, restart before runs are used up
        for (int s = 0; s < 10; s++) step(s, "R9");
        for (int s = 0; s < 4; s++) step(s, "R9");

        // R11: shorten rx program to one run
        wr(1'b1, 0, 2, 4, 1'b1, 1'b0, "R11");
        for (int s = 0; s < 6; s++) step(s, "R11");

        // R10: 64 single-slot tx runs, one 64-slot rx run
        for (int e = 0; e < 64; e++) wr(1'b0, e, 1, (e % 5) + 1, e == 63, 1'b0, "R10");
        wr(1'b1, 0, 64, 4, 1'b1, 1'b0, "R10");
        for (int s = 0; s < 67; s++) step(s, "R10");

        // R1: synchronous reset mid-frame clears selection
        for (int s = 0; s < 3; s++) step(s, "R10");
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 tx_act after reset", int'(tx_act), 0);
        chk("R1 ch_rx_we after reset", int'(ch_rx_we), 0);
        finish_run();
    end
endmodule